// File: doc/BRIEF.md
# Packed Quotient-Remainder Divider

This block divides a double-width dividend by a single-width divisor over several clock cycles. It writes the quotient and the remainder together into one double-width result register: the quotient goes in the low half and the remainder in the high half. Two operand sizes are supported. In the narrow size the dividend is 16 bits and the divisor is 8 bits. In the wide size the dividend is 32 bits and the divisor is 16 bits. Each size works either unsigned or signed.

A caller places the operands, the size select and the sign select on the inputs and raises `start` for one cycle. The block then raises `busy` and runs a restoring shift-subtract loop that produces one quotient bit per cycle. A final cycle applies the signs and writes the result and the two flags, and `done` pulses in that cycle. A zero divisor skips the loop. In that case the result register keeps its contents, and the zero flag reports the condition.

Top module: `packed_divider`

## Requirements
- R1: In narrow mode (`wide`=0) only `dividend[15:0]` and `divisor[7:0]` are used. The result takes the quotient in bits 7:0 and the remainder in bits 15:8.
- R2: In wide mode (`wide`=1) the full 32-bit dividend and 16-bit divisor are used. The result takes the quotient in bits 15:0 and the remainder in bits 31:16.
- R3: With `signed_op`=0 both operands are unsigned magnitudes, and the quotient and remainder are the unsigned results.
- R4: With `signed_op`=1 both operands are two's complement. The quotient is truncated toward zero, and a nonzero remainder has the sign of the dividend.
- R5: When the divisor is nonzero, `flag_n` equals the top bit of the quotient field: bit 7 in narrow mode and bit 15 in wide mode.
- R6: A divisor that is zero in the selected width sets `flag_z`=1 and `flag_n`=0 and leaves `result` unchanged. In that case `done` pulses one cycle after the start is accepted. A nonzero divisor clears `flag_z`.
- R7: A narrow-mode operation leaves `result[31:16]` unchanged.
- R8: `done` is a single-cycle pulse. It arrives 9 cycles after an accepted start in narrow mode and 17 cycles after in wide mode, counting the accepting edge as cycle 0.
- R9: A start is accepted when `busy` is low. `busy` rises at the accepting edge and stays high until the edge at which `done` rises. A start that arrives while `busy` is high is ignored and produces no result.
- R10: After reset, `result` is zero and `busy`, `done`, `flag_n` and `flag_z` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a division |
| wide | input | 1 | 1 selects the 32/16 size, 0 selects the 16/8 size |
| signed_op | input | 1 | 1 selects two's complement operands |
| dividend | input | 32 | Dividend |
| divisor | input | 16 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result and flags are written |
| result | output | 32 | Packed remainder (high half) and quotient (low half) |
| flag_n | output | 1 | Sign of the quotient |
| flag_z | output | 1 | Zero divisor seen |

## Verification
The result and flags of an accepted start are due 9 cycles later in narrow mode, 17 cycles later in wide mode, and 1 cycle later when the divisor is zero. The driver records the cycle number at which the start was taken and queues the expected packed result, the expected flags and this latency. The monitor samples `done` on falling edges. At each pulse it compares the outputs with the oldest queued item and the elapsed cycle count with the queued latency. A pulse that arrives with an empty queue is flagged, so a start issued while busy that wrongly produced a result would be caught.

// File: rtl/packed_divider.sv
module packed_divider #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            wide,
  input  logic            signed_op,
  input  logic [2*DW-1:0] dividend,
  input  logic [DW-1:0]   divisor,
  output logic            busy,
  output logic            done,
  output logic [2*DW-1:0] result,
  output logic            flag_n,
  output logic            flag_z
);
  localparam int HW = DW / 2;
  localparam int CW = $clog2(DW + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX} state_t;

  state_t          state;
  logic [DW-1:0]   rem;
  logic [DW-1:0]   quo;
  logic [DW-1:0]   dvs;
  logic [CW-1:0]   cnt;
  logic            mode_w;
  logic            neg_q;
  logic            neg_r;
  logic            dz;

  logic            a_neg, b_neg, b_zero, accept;
  logic [2*DW-1:0] a_sel, a_abs, a_mag;
  logic [DW-1:0]   b_sel, b_abs, b_mag;

  assign busy   = (state != S_IDLE);
  assign accept = start && !busy;

  assign a_neg = signed_op && (wide ? dividend[2*DW-1] : dividend[DW-1]);
  assign b_neg = signed_op && (wide ? divisor[DW-1] : divisor[HW-1]);
  assign a_sel = wide ? dividend : {{DW{1'b0}}, dividend[DW-1:0]};
  assign b_sel = wide ? divisor : {{HW{1'b0}}, divisor[HW-1:0]};
  assign a_abs = a_neg ? (~a_sel + 1'b1) : a_sel;
  assign b_abs = b_neg ? (~b_sel + 1'b1) : b_sel;
  assign a_mag = wide ? a_abs : {{DW{1'b0}}, a_abs[DW-1:0]};
  assign b_mag = wide ? b_abs : {{HW{1'b0}}, b_abs[HW-1:0]};
  assign b_zero = (b_sel == '0);

  logic [DW:0]   shifted;
  logic          fits;
  logic [DW-1:0] rem_next;

  assign shifted  = {rem, quo[DW-1]};
  assign fits     = (shifted >= {1'b0, dvs});
  assign rem_next = fits ? DW'(shifted - {1'b0, dvs}) : shifted[DW-1:0];

  logic [DW-1:0] q_mag, r_mag, q_fin, r_fin;

  assign q_mag = mode_w ? quo : {{HW{1'b0}}, quo[HW-1:0]};
  assign r_mag = mode_w ? rem : {{HW{1'b0}}, rem[HW-1:0]};
  assign q_fin = neg_q ? (~q_mag + 1'b1) : q_mag;
  assign r_fin = neg_r ? (~r_mag + 1'b1) : r_mag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      rem    <= '0;
      quo    <= '0;
      dvs    <= '0;
      cnt    <= '0;
      mode_w <= 1'b0;
      neg_q  <= 1'b0;
      neg_r  <= 1'b0;
      dz     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (accept) begin
            mode_w <= wide;
            neg_q  <= a_neg ^ b_neg;
            neg_r  <= a_neg;
            dz     <= b_zero;
            dvs    <= b_mag;
            rem    <= wide ? a_mag[2*DW-1:DW] : {{HW{1'b0}}, a_mag[DW-1:HW]};
            quo    <= wide ? a_mag[DW-1:0] : {a_mag[HW-1:0], {HW{1'b0}}};
            cnt    <= wide ? CW'(DW) : CW'(HW);
            state  <= b_zero ? S_FIX : S_RUN;
          end
        end
        S_RUN: begin
          rem <= rem_next;
          quo <= {quo[DW-2:0], fits};
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) state <= S_FIX;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      result <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else begin
      done <= (state == S_FIX);
      if (state == S_FIX) begin
        flag_z <= dz;
        if (dz) begin
          flag_n <= 1'b0;
        end else begin
          flag_n <= mode_w ? q_fin[DW-1] : q_fin[HW-1];
          if (mode_w) result <= {r_fin, q_fin};
          else        result[DW-1:0] <= {r_fin[HW-1:0], q_fin[HW-1:0]};
        end
      end
    end
  end
endmodule

module packed_divider_chk #(
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            wide,
  input logic [DW-1:0]   divisor,
  input logic            busy,
  input logic            done,
  input logic [2*DW-1:0] result,
  input logic            flag_n,
  input logic            flag_z
);
  localparam int HW = DW / 2;

  int   lat;
  int   lat_exp;
  logic mode_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat     <= 0;
      lat_exp <= 0;
      mode_w  <= 1'b0;
    end else if (start && !busy) begin
      lat     <= 0;
      mode_w  <= wide;
      if ((wide ? divisor : {{HW{1'b0}}, divisor[HW-1:0]}) == '0) lat_exp <= 1;
      else lat_exp <= (wide ? DW : HW) + 1;
    end else if (busy) begin
      lat <= lat + 1;
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy); // R9
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lat == lat_exp); // R8
  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    done && flag_z |-> result == $past(result)); // R6
  AST_ZERO_NO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    done && flag_z |-> !flag_n); // R6
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    done && !mode_w |-> result[2*DW-1:DW] == $past(result[2*DW-1:DW])); // R7
endmodule

bind packed_divider packed_divider_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wide(wide), .divisor(divisor),
  .busy(busy), .done(done), .result(result), .flag_n(flag_n), .flag_z(flag_z)
);

// File: tb/sim_packed_divider.sv
`timescale 1ns/1ps
module sim_packed_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        wide = 1'b0;
  logic        signed_op = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        busy, done, flag_n, flag_z;
  logic [31:0] result;

  always #2.5 clk = ~clk;

  packed_divider #(.DW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wide(wide), .signed_op(signed_op),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .result(result), .flag_n(flag_n), .flag_z(flag_z)
  );

  typedef struct {
    logic [31:0] res;
    logic        n;
    logic        z;
    int          lat;
    int          acc;
  } exp_t;

  exp_t  sb_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  logic [31:0] model_res = '0;
  bit    finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic run_op(input logic w, input logic s, input logic [31:0] a,
                        input logic [15:0] b, input string req);
    longint sa, sb, qq, rr;
    exp_t   e;
    logic [15:0] qf, rf;
    while (busy) @(negedge clk);
    if (w) begin
      sa = s ? longint'($signed(a)) : longint'(a);
      sb = s ? longint'($signed(b)) : longint'(b);
    end else begin
      sa = s ? longint'($signed(a[15:0])) : longint'(a[15:0]);
      sb = s ? longint'($signed(b[7:0])) : longint'(b[7:0]);
    end
    e.z = (sb == 0);
    if (e.z) begin
      e.n = 1'b0;
      e.lat = 1;
    end else begin
      qq = sa / sb;
      rr = sa % sb;
      qf = qq[15:0];
      rf = rr[15:0];
      if (w) begin
        model_res = {rf, qf};
        e.n = qf[15];
        e.lat = 17;
      end else begin
        model_res[15:0] = {rf[7:0], qf[7:0]};
        e.n = qf[7];
        e.lat = 9;
      end
    end
    e.res = model_res;
    wide = w; signed_op = s; dividend = a; divisor = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    e.acc = cyc;
    sb_q.push_back(e);
    tag_q.push_back(req);
    check(busy == 1'b1, "R9", "busy after accept", {31'd0, busy}, 32'd1);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R9", "done with no accepted start", 32'd1, 32'd0);
      end else begin
        exp_t e;
        string t;
        e = sb_q.pop_front();
        t = tag_q.pop_front();
        check(result == e.res, t, "result", result, e.res);
        check(flag_n == e.n, "R5", "flag_n", {31'd0, flag_n}, {31'd0, e.n});
        check(flag_z == e.z, "R6", "flag_z", {31'd0, flag_z}, {31'd0, e.z});
        check(cyc - e.acc == e.lat, "R8", "latency", cyc - e.acc, e.lat);
        check(busy == 1'b0, "R9", "busy low with done", {31'd0, busy}, 32'd0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(result == 32'd0, "R10", "reset result", result, 32'd0);
    check({busy, done, flag_n, flag_z} == 4'd0, "R10", "reset controls",
          {28'd0, busy, done, flag_n, flag_z}, 32'd0);

    run_op(1'b0, 1'b0, 32'h0000_03E8, 16'h0007, "R1 R3 narrow unsigned");
    run_op(1'b0, 1'b0, 32'hABCD_03E8, 16'h5507, "R1 narrow ignores upper inputs");
    run_op(1'b0, 1'b1, 32'h0000_FF9C, 16'h0007, "R4 narrow neg/pos");
    run_op(1'b0, 1'b1, 32'h0000_0064, 16'h00F9, "R4 narrow pos/neg");
    run_op(1'b0, 1'b1, 32'h0000_FF9C, 16'h00F9, "R4 narrow neg/neg");
    run_op(1'b0, 1'b1, 32'h0000_FF00, 16'h0002, "R4 R5 narrow most negative quotient");
    run_op(1'b1, 1'b0, 32'd1000000, 16'd300, "R2 R3 wide unsigned");
    run_op(1'b1, 1'b1, -32'sd1000000, 16'd300, "R2 R4 wide signed");
    run_op(1'b1, 1'b1, 32'd1000000, -16'sd300, "R4 wide pos/neg");
    run_op(1'b1, 1'b0, 32'h1234_5678, 16'hFFFF, "R2 R3 wide max divisor");
    run_op(1'b0, 1'b0, 32'h0000_1234, 16'h0100, "R6 R7 narrow zero divisor");
    run_op(1'b1, 1'b1, 32'h0000_0040, 16'h0000, "R6 wide zero divisor");
    run_op(1'b0, 1'b0, 32'h0000_00FE, 16'h0010, "R7 narrow keeps upper half");

    for (int i = 1; i <= 12; i++) begin
      logic [15:0] d, qv, rv;
      d  = 16'(i * 977 + 5);
      qv = 16'(i * 4099);
      rv = 16'((i * 13) % int'(d));
      run_op(1'b1, 1'b0, 32'(longint'(d) * longint'(qv) + longint'(rv)), d,
             "R2 R3 wide sweep");
    end

    run_op(1'b1, 1'b0, 32'd999999, 16'd1000, "R9 start ignored while busy");
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R9", "busy mid-operation", {31'd0, busy}, 32'd1);
    wide = 1'b0; signed_op = 1'b0; dividend = 32'h0000_0010; divisor = 16'h0003;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    check(sb_q.size() == 0, "R9", "no pending result", sb_q.size(), 32'd0);
    check(result == model_res, "R9", "ignored start left result", result, model_res);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule